// File: doc/BRIEF.md
# Processor Exception Sequencer

This block decides, cycle by cycle, whether a simple in-order core must leave its instruction stream for an exception handler. It also records where execution should resume and which status word was live at that moment. It watches four groups of inputs:

- the completion of the instruction in the execution units, together with any fault that instruction raises;
- three interrupt lines that the status word's enable bit can mask;
- two urgent lines that cannot be masked;
- the core's busy indication.

When it takes an exception, it emits a one-cycle take strobe with a 4-bit vector code. On the same edge it latches the restart address and a copy of the previous status word, and it rewrites the live status word: the enable bit is cleared and the recoverable bit reports whether the saved state can be trusted.

Faults raised by instructions are precise. A faulting instruction never commits. The saved address is the faulting instruction's own address, except for trap and system-call requests, which save the following address so that the handler can choose where to resume. A maskable interrupt never cuts an instruction short. It waits while an instruction is still in flight and is taken on the cycle that instruction completes. If the pipeline is empty, it is taken at once. Software writes the status word through a write port, which is how a handler re-enables interrupts.

Top module: `exc_seq`

## Requirements
- R1: When several sources are active together, exactly one exception is taken, chosen in the order: reset line, machine-check line, a fault of the completing instruction, external line, system-management line, decrement-timer line.
- R2: `take_o` is high for exactly one cycle per exception. Inputs are ignored in that cycle, so a source held active produces a take every second cycle.
- R3: A fault (`insn_done` and `fault_req` both high) of kind 0 (access) or kind 1 (program) saves `fault_pc` in `srr0_o`. `commit_o` is low in that cycle. `fault_req` without `insn_done` has no effect.
- R4: A fault of kind 2 (trap) or kind 3 (system call) saves `fault_pc` + 4 in `srr0_o`.
- R5: The maskable lines have no effect while status bit 15 (interrupt enable) is 0.
- R6: While `insn_busy` is high and `insn_done` is low, a pending enabled maskable interrupt waits. It is taken on the cycle `insn_done` rises; that instruction still commits, and `srr0_o` is `resume_pc`.
- R7: With `insn_busy` low, a pending enabled maskable interrupt is taken at the next clock edge, saving `resume_pc`.
- R8: The reset and machine-check lines are taken whatever status bit 15 holds, saving `resume_pc`.
- R9: On a take, `srr1_o` gets the status word from before the edge. In the live status word, bit 15 is cleared, and bit 1 (recoverable) is 0 for reset and machine check and 1 otherwise. `recov_o` equals that bit 1.
- R10: A fault beats a maskable interrupt raised in the same cycle. The interrupt stays pending and is taken once software sets bit 15 again.
- R11: Vector codes: reset 1, machine check 2, access 3, trap 4, system call 5, program 6, external 8, system management 9, decrement timer 10.
- R12: Under reset, `take_o`, `commit_o`, `vec_o`, `srr0_o`, `srr1_o`, `recov_o` and `stat_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_busy | input | 1 | An instruction occupies the execution units |
| insn_done | input | 1 | That instruction completes this cycle |
| fault_req | input | 1 | The completing instruction raises a fault |
| fault_kind | input | 2 | 0 access, 1 program, 2 trap, 3 system call |
| fault_pc | input | 32 | Address of the faulting instruction |
| resume_pc | input | 32 | Address of the next instruction not yet completed |
| irq_ext | input | 1 | External interrupt, level, maskable |
| irq_smi | input | 1 | System-management interrupt, level, maskable |
| irq_dec | input | 1 | Decrement-timer interrupt, level, maskable |
| nmi_reset | input | 1 | Reset exception line, unmaskable |
| nmi_mchk | input | 1 | Machine-check line, unmaskable |
| stat_we | input | 1 | Write the status word |
| stat_wd | input | 16 | Status word write data |
| take_o | output | 1 | One-cycle take-exception strobe |
| vec_o | output | 4 | Vector code of the exception taken |
| srr0_o | output | 32 | Saved restart address |
| srr1_o | output | 16 | Saved status word |
| recov_o | output | 1 | Saved state is recoverable |
| stat_o | output | 16 | Live status word |
| commit_o | output | 1 | The completing instruction is allowed to commit |

## Verification
A table drives each source alone, masked and unmasked combinations of the three maskable lines, pairs of urgent lines, and faults of every kind raised alongside interrupts, so that the vector code shows which priority won. Per-kind faults tell apart a precise save (`fault_pc`) from the step-over save used by trap and system call. Directed sequences separate the in-flight case, where the interrupt waits for completion, from the empty-pipeline case. A held reset line shows the take strobe alternating. A fault raised with an interrupt shows that the interrupt survives and fires only after the enable bit is rewritten.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_DRAIN = 2'd1,
        ST_TAKE  = 2'd2
    } seq_state_e;

    localparam logic [3:0] VEC_NONE      = 4'd0;
    localparam logic [3:0] VEC_RESET     = 4'd1;
    localparam logic [3:0] VEC_MCHK      = 4'd2;
    localparam logic [3:0] VEC_ACCESS    = 4'd3;
    localparam logic [3:0] VEC_TRAP      = 4'd4;
    localparam logic [3:0] VEC_SYSCALL   = 4'd5;
    localparam logic [3:0] VEC_PROGRAM   = 4'd6;
    localparam logic [3:0] VEC_MASK_BASE = 4'd8;

    localparam logic [1:0] FK_ACCESS  = 2'd0;
    localparam logic [1:0] FK_PROGRAM = 2'd1;
    localparam logic [1:0] FK_TRAP    = 2'd2;
    localparam logic [1:0] FK_SYSCALL = 2'd3;
endpackage

// File: rtl/exc_irq_gate.sv
module exc_irq_gate #(
    parameter int N = 3
) (
    input  logic [N-1:0] lines_i,
    input  logic         enable_i,
    output logic [N-1:0] pend_o,
    output logic         any_o
);
    for (genvar i = 0; i < N; i++) begin : g_gate
        assign pend_o[i] = lines_i[i] & enable_i;
    end
    assign any_o = |pend_o;
endmodule

// File: rtl/exc_prio.sv
module exc_prio
    import exc_seq_pkg::*;
#(
    parameter int N = 3
) (
    input  logic         nmi_reset_i,
    input  logic         nmi_mchk_i,
    input  logic         sync_hit_i,
    input  logic [1:0]   fault_kind_i,
    input  logic [N-1:0] pend_i,
    output logic [3:0]   vec_o,
    output logic         nonrec_o,
    output logic         use_fault_pc_o,
    output logic         step_pc_o
);
    logic [3:0] mask_vec;

    // lowest index wins among the maskable lines
    always_comb begin
        mask_vec = VEC_NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_i[i]) mask_vec = VEC_MASK_BASE + 4'(i);
        end
    end

    always_comb begin
        nonrec_o       = 1'b0;
        use_fault_pc_o = 1'b0;
        step_pc_o      = 1'b0;
        if (nmi_reset_i) begin
            vec_o    = VEC_RESET;
            nonrec_o = 1'b1;
        end else if (nmi_mchk_i) begin
            vec_o    = VEC_MCHK;
            nonrec_o = 1'b1;
        end else if (sync_hit_i) begin
            use_fault_pc_o = 1'b1;
            unique case (fault_kind_i)
                FK_ACCESS:  vec_o = VEC_ACCESS;
                FK_PROGRAM: vec_o = VEC_PROGRAM;
                FK_TRAP:    begin vec_o = VEC_TRAP;    step_pc_o = 1'b1; end
                FK_SYSCALL: begin vec_o = VEC_SYSCALL; step_pc_o = 1'b1; end
                default:    vec_o = VEC_ACCESS;
            endcase
        end else begin
            vec_o = mask_vec;
        end
    end
endmodule

// File: rtl/exc_save.sv
module exc_save #(
    parameter int PC_W       = 32,
    parameter int SW         = 16,
    parameter int EE_BIT     = 15,
    parameter int RI_BIT     = 1,
    parameter int INSN_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture_i,
    input  logic [3:0]      vec_i,
    input  logic            nonrec_i,
    input  logic            use_fault_pc_i,
    input  logic            step_pc_i,
    input  logic [PC_W-1:0] fault_pc_i,
    input  logic [PC_W-1:0] resume_pc_i,
    input  logic            stat_we_i,
    input  logic [SW-1:0]   stat_wd_i,
    output logic [SW-1:0]   stat_o,
    output logic [PC_W-1:0] srr0_o,
    output logic [SW-1:0]   srr1_o,
    output logic [3:0]      vec_o,
    output logic            recov_o
);
    localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

    logic [SW-1:0]   stat_q, stat_exc;
    logic [PC_W-1:0] save_pc;

    always_comb begin
        stat_exc         = stat_q;
        stat_exc[EE_BIT] = 1'b0;
        stat_exc[RI_BIT] = ~nonrec_i;
    end

    always_comb begin
        if (!use_fault_pc_i)  save_pc = resume_pc_i;
        else if (step_pc_i)   save_pc = fault_pc_i + STEP;
        else                  save_pc = fault_pc_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q  <= '0;
            srr0_o  <= '0;
            srr1_o  <= '0;
            vec_o   <= '0;
            recov_o <= 1'b0;
        end else if (capture_i) begin
            srr1_o  <= stat_q;
            stat_q  <= stat_exc;
            srr0_o  <= save_pc;
            vec_o   <= vec_i;
            recov_o <= ~nonrec_i;
        end else if (stat_we_i) begin
            stat_q  <= stat_wd_i;
        end
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/exc_seq.sv
module exc_seq
    import exc_seq_pkg::*;
#(
    parameter int PC_W       = 32,
    parameter int SW         = 16,
    parameter int EE_BIT     = 15,
    parameter int RI_BIT     = 1,
    parameter int INSN_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            insn_busy,
    input  logic            insn_done,
    input  logic            fault_req,
    input  logic [1:0]      fault_kind,
    input  logic [PC_W-1:0] fault_pc,
    input  logic [PC_W-1:0] resume_pc,
    input  logic            irq_ext,
    input  logic            irq_smi,
    input  logic            irq_dec,
    input  logic            nmi_reset,
    input  logic            nmi_mchk,
    input  logic            stat_we,
    input  logic [SW-1:0]   stat_wd,
    output logic            take_o,
    output logic [3:0]      vec_o,
    output logic [PC_W-1:0] srr0_o,
    output logic [SW-1:0]   srr1_o,
    output logic            recov_o,
    output logic [SW-1:0]   stat_o,
    output logic            commit_o
);
    localparam int NMASK = 3;

    seq_state_e       state_q, state_d;
    logic [NMASK-1:0] pend;
    logic             pend_any, sync_hit, urgent, capture;
    logic [3:0]       win_vec;
    logic             nonrec, use_fault_pc, step_pc;

    assign sync_hit = insn_done & fault_req;
    assign urgent   = nmi_reset | nmi_mchk | sync_hit;

    exc_irq_gate #(.N(NMASK)) u_gate (
        .lines_i  ({irq_dec, irq_smi, irq_ext}),
        .enable_i (stat_o[EE_BIT]),
        .pend_o   (pend),
        .any_o    (pend_any)
    );

    exc_prio #(.N(NMASK)) u_prio (
        .nmi_reset_i    (nmi_reset),
        .nmi_mchk_i     (nmi_mchk),
        .sync_hit_i     (sync_hit),
        .fault_kind_i   (fault_kind),
        .pend_i         (pend),
        .vec_o          (win_vec),
        .nonrec_o       (nonrec),
        .use_fault_pc_o (use_fault_pc),
        .step_pc_o      (step_pc)
    );

    exc_save #(
        .PC_W(PC_W), .SW(SW), .EE_BIT(EE_BIT), .RI_BIT(RI_BIT), .INSN_BYTES(INSN_BYTES)
    ) u_save (
        .clk            (clk),
        .rst_n          (rst_n),
        .capture_i      (capture),
        .vec_i          (win_vec),
        .nonrec_i       (nonrec),
        .use_fault_pc_i (use_fault_pc),
        .step_pc_i      (step_pc),
        .fault_pc_i     (fault_pc),
        .resume_pc_i    (resume_pc),
        .stat_we_i      (stat_we),
        .stat_wd_i      (stat_wd),
        .stat_o         (stat_o),
        .srr0_o         (srr0_o),
        .srr1_o         (srr1_o),
        .vec_o          (vec_o),
        .recov_o        (recov_o)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // transitions: RUN/DRAIN -> TAKE on a winner, RUN -> DRAIN while in flight
    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        unique case (state_q)
            ST_RUN, ST_DRAIN: begin
                if (urgent) begin
                    state_d = ST_TAKE;
                    capture = 1'b1;
                end else if (pend_any) begin
                    if (!insn_busy || insn_done) begin
                        state_d = ST_TAKE;
                        capture = 1'b1;
                    end else begin
                        state_d = ST_DRAIN;
                    end
                end else begin
                    state_d = ST_RUN;
                end
            end
            ST_TAKE: state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        take_o   = (state_q == ST_TAKE);
        commit_o = insn_done & ~fault_req & ~nmi_reset & ~nmi_mchk
                   & (state_q != ST_TAKE);
    end
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk #(
    parameter int SW     = 16,
    parameter int EE_BIT = 15,
    parameter int RI_BIT = 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          insn_busy,
    input logic          insn_done,
    input logic          fault_req,
    input logic          nmi_reset,
    input logic          nmi_mchk,
    input logic          take_o,
    input logic [3:0]    vec_o,
    input logic [SW-1:0] srr1_o,
    input logic          recov_o,
    input logic [SW-1:0] stat_o,
    input logic          commit_o
);
    assert_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);

    assert_reset_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_o && nmi_reset) |=> (take_o && vec_o == 4'd1));

    assert_mchk_unmasked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_o && !nmi_reset && nmi_mchk) |=> (take_o && vec_o == 4'd2));

    assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_o && !stat_o[EE_BIT] && !nmi_reset && !nmi_mchk
         && !(insn_done && fault_req)) |=> !take_o);

    assert_wait_in_flight_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_o && insn_busy && !insn_done && !nmi_reset && !nmi_mchk) |=> !take_o);

    assert_no_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_done && fault_req) |-> !commit_o);

    assert_srr1_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (srr1_o == $past(stat_o)));

    assert_ee_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (!stat_o[EE_BIT] && stat_o[RI_BIT] == recov_o));

    assert_recov_R9: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (recov_o == (vec_o > 4'd2)));
endmodule

bind exc_seq exc_seq_chk #(.SW(SW), .EE_BIT(EE_BIT), .RI_BIT(RI_BIT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .insn_busy (insn_busy),
    .insn_done (insn_done),
    .fault_req (fault_req),
    .nmi_reset (nmi_reset),
    .nmi_mchk  (nmi_mchk),
    .take_o    (take_o),
    .vec_o     (vec_o),
    .srr1_o    (srr1_o),
    .recov_o   (recov_o),
    .stat_o    (stat_o),
    .commit_o  (commit_o)
);

// File: tb/exc_seq_test.sv
module exc_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_busy = 0, insn_done = 0, fault_req = 0;
    logic [1:0]  fault_kind = 0;
    logic [31:0] fault_pc = 32'h1000_0040, resume_pc = 32'h2000_0100;
    logic        irq_ext = 0, irq_smi = 0, irq_dec = 0, nmi_reset = 0, nmi_mchk = 0;
    logic        stat_we = 0;
    logic [15:0] stat_wd = 0;
    logic        take_o, recov_o, commit_o;
    logic [3:0]  vec_o;
    logic [31:0] srr0_o;
    logic [15:0] srr1_o, stat_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    exc_seq uut (.*);

    // fields: ee busy done fault kind[1:0] ext smi dec rst mchk take vec[3:0]
    localparam logic [15:0] TBL [17] = '{
        16'b1_0_0_0_00_1_0_0_0_0_1_1000,
        16'b1_0_0_0_00_0_1_0_0_0_1_1001,
        16'b1_0_0_0_00_0_0_1_0_0_1_1010,
        16'b1_0_0_0_00_1_1_1_0_0_1_1000,
        16'b1_0_0_0_00_0_1_1_0_0_1_1001,
        16'b0_0_0_0_00_1_1_1_0_0_0_0000,
        16'b0_0_0_0_00_0_0_0_1_0_1_0001,
        16'b0_0_0_0_00_0_0_0_0_1_1_0010,
        16'b1_0_0_0_00_1_0_0_1_1_1_0001,
        16'b1_1_1_1_00_0_0_0_0_1_1_0010,
        16'b1_1_1_1_00_1_0_0_0_0_1_0011,
        16'b0_1_1_1_01_0_0_0_0_0_1_0110,
        16'b0_1_1_1_10_0_0_0_0_0_1_0100,
        16'b0_1_1_1_11_0_0_0_0_0_1_0101,
        16'b1_1_0_0_00_1_0_0_0_0_0_0000,
        16'b1_1_1_0_00_1_0_0_0_0_1_1000,
        16'b1_1_0_1_00_0_0_0_0_0_0_0000
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_inputs();
        insn_busy = 0; insn_done = 0; fault_req = 0; fault_kind = 0;
        irq_ext = 0; irq_smi = 0; irq_dec = 0; nmi_reset = 0; nmi_mchk = 0;
        stat_we = 0;
    endtask

    task automatic write_stat(input logic [15:0] w);
        @(negedge clk);
        clear_inputs();
        stat_we = 1; stat_wd = w;
        @(negedge clk);
        stat_we = 0;
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R12: reset state
        #12;
        chk("R12 take", 32'(take_o), 0);
        chk("R12 commit", 32'(commit_o), 0);
        chk("R12 stat", 32'(stat_o), 0);
        chk("R12 srr0", srr0_o, 0);
        chk("R12 srr1/vec/recov", {srr1_o, 11'd0, recov_o, vec_o}, 0);
        @(negedge clk); rst_n = 1;
        @(negedge clk);

        // table of single-shot scenarios
        foreach (TBL[k]) begin
            logic [15:0] e = TBL[k];
            logic [15:0] w = e[15] ? 16'h8002 : 16'h0002;
            logic [3:0]  xv = e[3:0];
            logic        xr = (xv > 4'd2);
            logic [31:0] xpc;
            logic        xcommit;
            write_stat(w);
            insn_busy = e[14]; insn_done = e[13]; fault_req = e[12]; fault_kind = e[11:10];
            irq_ext = e[9]; irq_smi = e[8]; irq_dec = e[7]; nmi_reset = e[6]; nmi_mchk = e[5];
            #1;
            xcommit = e[13] & ~e[12] & ~e[6] & ~e[5];
            chk("R3/R6 commit", 32'(commit_o), 32'(xcommit));
            @(negedge clk);
            clear_inputs();
            chk("R1/R5/R7 take", 32'(take_o), 32'(e[4]));
            if (e[4]) begin
                if (xv == 4'd3 || xv == 4'd6)      xpc = fault_pc;
                else if (xv == 4'd4 || xv == 4'd5) xpc = fault_pc + 32'd4;
                else                               xpc = resume_pc;
                chk("R11 vector", 32'(vec_o), 32'(xv));
                chk("R3/R4/R7/R8 srr0", srr0_o, xpc);
                chk("R9 srr1", 32'(srr1_o), 32'(w));
                chk("R9 stat", 32'(stat_o), 32'((w & 16'h7FFD) | {14'd0, xr, 1'b0}));
                chk("R9 recov", 32'(recov_o), 32'(xr));
            end
            @(negedge clk);
        end

        // R2: held reset line gives take every second cycle
        write_stat(16'h0002);
        nmi_reset = 1;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            chk("R2 pulse", 32'(take_o), (c % 2 == 0) ? 1 : 0);
        end
        clear_inputs();
        @(negedge clk);

        // R6: interrupt waits for the in-flight instruction
        write_stat(16'h8002);
        insn_busy = 1; irq_ext = 1;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk("R6 waits", 32'(take_o), 0);
        end
        insn_done = 1; resume_pc = 32'h2000_0200;
        #1 chk("R6 commit", 32'(commit_o), 1);
        @(negedge clk);
        clear_inputs();
        chk("R6 take", 32'(take_o), 1);
        chk("R6 vector", 32'(vec_o), 8);
        chk("R6 srr0", srr0_o, 32'h2000_0200);
        @(negedge clk);

        // R10: fault beats interrupt; interrupt survives until re-enabled
        write_stat(16'h8002);
        insn_busy = 1; insn_done = 1; fault_req = 1; fault_kind = 2'd0; irq_smi = 1;
        @(negedge clk);
        insn_busy = 0; insn_done = 0; fault_req = 0;
        chk("R10 fault wins", 32'(vec_o), 3);
        for (int c = 0; c < 2; c++) begin
            @(negedge clk);
            chk("R10 held off", 32'(take_o), 0);
        end
        stat_we = 1; stat_wd = 16'h8002;
        @(negedge clk);
        stat_we = 0;
        chk("R10 not yet", 32'(take_o), 0);
        @(negedge clk);
        chk("R10 taken", 32'(take_o), 1);
        chk("R10 vector", 32'(vec_o), 9);
        clear_inputs();
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule